// File: doc/BRIEF.md
# Key Combination Detector with Precondition Hold

This block watches five active-low key inputs (three keys, a power button and an AC-present line). It recognises up to four programmable key combinations. Each key first passes through its own debouncer. All debouncers share one stability count. Each combination detector can require a chosen set of "precondition" keys to stay pressed for a programmed number of ticks before it arms. Once armed, it waits for its chosen combination keys to become pressed together, and it requires them to stay pressed for a second programmed number of ticks.

When a combination is recognised, the block fires the actions enabled for that detector. The possible actions are a battery-cut strobe, an interrupt status bit, a stretched active-low EC reset pulse and a system reset strobe. When several detectors fire in the same cycle, their actions are merged with OR. All timing is measured in ticks of an external timebase strobe. Configuration is taken as plain input levels, so the register file and pad logic live outside this block.

Top module: `key_combo_ctrl`

## Requirements
- R1: After reset, `act_o` is 0, `combo_stat_o` is 0, `irq_o` is 0 and `ec_rst_l_o` is 1.
- R2: A key is pressed when its `key_i` bit is 0. A new raw key level is accepted only after it has differed from the accepted level for more than `deb_time_i` ticks. A shorter glitch is ignored.
- R3: Both key-select masks use bit0 key0, bit1 key1, bit2 key2, bit3 power button and bit4 AC present. An armed detector starts its combination hold when its selected combination keys change from not-all-pressed to all-pressed. It fires once they have stayed pressed for `com_time` ticks.
- R4: If any selected combination key is released before the hold time ends, the detector returns to idle without firing.
- R5: With a non-empty precondition mask, the detector arms only after all selected precondition keys have been pressed for `pre_time` ticks. Releasing any of them earlier, or at any later point before firing, returns the detector to idle. An empty precondition mask arms the detector at once.
- R6: If the combination keys are already all pressed when the detector arms, nothing fires. They must be released and pressed again.
- R7: A detector whose combination mask is zero never fires and never sets its status bit.
- R8: After firing, a detector does not fire again until all of its selected combination keys have been released.
- R9: The action mask bit order is bit0 battery cut, bit1 interrupt, bit2 EC reset, bit3 reset request. `act_o` pulses for one cycle with the enabled actions of every detector that fires in that cycle, merged with OR.
- R10: A detector's `combo_stat_o` bit is set on firing only if its interrupt action is enabled. The bit stays set until a 1 is applied on the matching `stat_clr_i` bit. `irq_o` is the OR of all status bits.
- R11: An EC reset action drives `ec_rst_l_o` low for `ec_width_i` ticks after the trigger cycle, which is `ec_width_i`+1 clock cycles when `tick_i` is held high.
- R12: Debounce, precondition and combination timers advance only in cycles where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase strobe; timers count these |
| key_i | input | 5 | Raw key levels, 0 = pressed |
| deb_time_i | input | 16 | Shared debounce count in ticks |
| pre_sel_i | input | 20 | Precondition key mask, 5 bits per detector |
| com_sel_i | input | 20 | Combination key mask, 5 bits per detector |
| pre_time_i | input | 128 | Precondition hold ticks, 32 bits per detector |
| com_time_i | input | 128 | Combination hold ticks, 32 bits per detector |
| act_en_i | input | 16 | Enabled actions, 4 bits per detector |
| ec_width_i | input | 16 | EC reset pulse width in ticks |
| stat_clr_i | input | 4 | Write-one-to-clear for the status bits |
| act_o | output | 4 | One-cycle merged action strobe |
| combo_stat_o | output | 4 | Sticky per-detector status |
| irq_o | output | 1 | Interrupt, OR of status bits |
| ec_rst_l_o | output | 1 | Active-low stretched EC reset |

## Verification
The bench chases the points where the detector sequence is easy to get wrong. It applies a two-cycle glitch that a missing debounce would turn into a zero-length combination. It releases keys early, which a design without a fall-back would still fire on. It presses the combination keys before the precondition completes, which level-based matching instead of edge-based matching would wrongly fire on. It also holds the keys long after firing, which a design that re-arms straight from the done state would fire on again. It stalls the tick to catch timers that count clocks instead of ticks. It fires two detectors in the same cycle to check the OR merge. It measures the EC pulse width to the cycle, and it checks that a detector without the interrupt action leaves its status bit clear.

// File: rtl/combo_pkg.sv
package combo_pkg;
  localparam int NUM_KEYS = 5;
  localparam int ACT_W    = 4;
  localparam int ACT_BAT  = 0;
  localparam int ACT_IRQ  = 1;
  localparam int ACT_EC   = 2;
  localparam int ACT_RST  = 3;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_PRE,
    CS_ARMED,
    CS_HOLD,
    CS_DONE
  } combo_st_e;
endpackage

// File: rtl/key_debounce.sv
module key_debounce #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          raw_i,
  input  logic [CW-1:0] limit_i,
  output logic          level_o
);
  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else if (raw_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q >= limit_i) begin
      lvl_q <= raw_i;
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign level_o = lvl_q;

  // accepted level only ever moves to the raw value seen at that edge
  p_level_follows_raw_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> ($past(raw_i) == lvl_q));
endmodule

// File: rtl/combo_fsm.sv
module combo_fsm import combo_pkg::*; #(
  parameter int NK = NUM_KEYS,
  parameter int TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [NK-1:0] keys_i,
  input  logic [NK-1:0] pre_sel_i,
  input  logic [NK-1:0] com_sel_i,
  input  logic [TW-1:0] pre_time_i,
  input  logic [TW-1:0] com_time_i,
  output logic          fire_o
);
  combo_st_e     st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          fire_q, fire_d;
  logic          low_q;
  logic          com_en, pre_ok, com_low, com_rel;

  assign com_en  = |com_sel_i;
  assign pre_ok  = ((~keys_i) & pre_sel_i) == pre_sel_i;
  assign com_low = com_en && (((~keys_i) & com_sel_i) == com_sel_i);
  assign com_rel = (keys_i & com_sel_i) == com_sel_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (!com_en) begin
      st_d  = CS_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        CS_IDLE: begin
          cnt_d = '0;
          if (pre_sel_i == '0)  st_d = CS_ARMED;
          else if (pre_ok)      st_d = CS_PRE;
        end
        CS_PRE: begin
          if (!pre_ok) begin
            st_d = CS_IDLE;
          end else if (cnt_q >= pre_time_i) begin
            st_d  = CS_ARMED;
            cnt_d = '0;
          end else if (tick_i) begin
            cnt_d = cnt_q + TW'(1);
          end
        end
        CS_ARMED: begin
          if (!pre_ok) begin
            st_d = CS_IDLE;
          end else if (com_low && !low_q) begin
            // edge-qualified: keys must go pressed after arming
            st_d  = CS_HOLD;
            cnt_d = '0;
          end
        end
        CS_HOLD: begin
          if (!pre_ok || !com_low) begin
            st_d = CS_IDLE;
          end else if (cnt_q >= com_time_i) begin
            st_d   = CS_DONE;
            fire_d = 1'b1;
          end else if (tick_i) begin
            cnt_d = cnt_q + TW'(1);
          end
        end
        CS_DONE: begin
          if (com_rel) st_d = CS_IDLE;
        end
        default: st_d = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CS_IDLE;
      cnt_q  <= '0;
      fire_q <= 1'b0;
      low_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
      low_q  <= com_low;
    end
  end

  assign fire_o = fire_q;

  p_fire_one_shot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  p_fire_keys_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(com_low));
  p_disabled_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !com_en |=> !fire_o);
endmodule

// File: rtl/ec_pulse_gen.sv
module ec_pulse_gen #(
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          trig_i,
  input  logic [PW-1:0] width_i,
  output logic          ec_rst_l_o
);
  logic          act_q;
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (trig_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q >= width_i)  act_q <= 1'b0;
      else if (tick_i)       cnt_q <= cnt_q + PW'(1);
    end
  end

  assign ec_rst_l_o = ~act_q;

  p_trig_drives_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> !ec_rst_l_o);
endmodule

// File: rtl/key_combo_ctrl.sv
module key_combo_ctrl import combo_pkg::*; #(
  parameter int NC = 4,
  parameter int TW = 32,
  parameter int PW = 16,
  parameter int DW = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [NUM_KEYS-1:0]   key_i,
  input  logic [DW-1:0]         deb_time_i,
  input  logic [NC*NUM_KEYS-1:0] pre_sel_i,
  input  logic [NC*NUM_KEYS-1:0] com_sel_i,
  input  logic [NC*TW-1:0]      pre_time_i,
  input  logic [NC*TW-1:0]      com_time_i,
  input  logic [NC*ACT_W-1:0]   act_en_i,
  input  logic [PW-1:0]         ec_width_i,
  input  logic [NC-1:0]         stat_clr_i,
  output logic [ACT_W-1:0]      act_o,
  output logic [NC-1:0]         combo_stat_o,
  output logic                  irq_o,
  output logic                  ec_rst_l_o
);
  localparam int NK = NUM_KEYS;

  logic [NK-1:0]    key_db;
  logic [NC-1:0]    fire_w;
  logic [NC-1:0]    stat_q, stat_set;
  logic [ACT_W-1:0] act_v;

  for (genvar k = 0; k < NK; k++) begin : g_deb
    key_debounce #(.CW(DW)) u_deb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .raw_i   (key_i[k]),
      .limit_i (deb_time_i),
      .level_o (key_db[k])
    );
  end

  for (genvar c = 0; c < NC; c++) begin : g_combo
    combo_fsm #(.NK(NK), .TW(TW)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .keys_i     (key_db),
      .pre_sel_i  (pre_sel_i[c*NK +: NK]),
      .com_sel_i  (com_sel_i[c*NK +: NK]),
      .pre_time_i (pre_time_i[c*TW +: TW]),
      .com_time_i (com_time_i[c*TW +: TW]),
      .fire_o     (fire_w[c])
    );
    assign stat_set[c] = fire_w[c] & act_en_i[c*ACT_W + ACT_IRQ];

    p_stat_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stat_q[c]) |-> $past(fire_w[c] && act_en_i[c*ACT_W + ACT_IRQ]));
  end

  always_comb begin
    act_v = '0;
    for (int c = 0; c < NC; c++) begin
      for (int b = 0; b < ACT_W; b++) begin
        act_v[b] = act_v[b] | (fire_w[c] & act_en_i[c*ACT_W + b]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~stat_clr_i) | stat_set;
  end

  ec_pulse_gen #(.PW(PW)) u_ec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .trig_i     (act_v[ACT_EC]),
    .width_i    (ec_width_i),
    .ec_rst_l_o (ec_rst_l_o)
  );

  assign act_o        = act_v;
  assign combo_stat_o = stat_q;
  assign irq_o        = |stat_q;

  p_act_needs_fire_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o != '0) |-> (fire_w != '0));
endmodule

// File: tb/sim_key_combo_ctrl.sv
module sim_key_combo_ctrl;
  localparam int NC = 4, NK = 5, TW = 32, PW = 16, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic [NK-1:0]    keys = '1;
  logic [DW-1:0]    deb_time = 16'd3;
  logic [NC*NK-1:0] pre_sel, com_sel;
  logic [NC*TW-1:0] pre_time, com_time;
  logic [NC*4-1:0]  act_en;
  logic [PW-1:0]    ec_width = 16'd15;
  logic [NC-1:0]    stat_clr = '0;
  logic [3:0]       act;
  logic [NC-1:0]    stat;
  logic             irq, ec_l;

  int vec = 0, bad = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] e_act;
  string      e_tag;

  always #10 clk = ~clk;

  key_combo_ctrl #(.NC(NC), .TW(TW), .PW(PW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .key_i(keys),
    .deb_time_i(deb_time), .pre_sel_i(pre_sel), .com_sel_i(com_sel),
    .pre_time_i(pre_time), .com_time_i(com_time), .act_en_i(act_en),
    .ec_width_i(ec_width), .stat_clr_i(stat_clr), .act_o(act),
    .combo_stat_o(stat), .irq_o(irq), .ec_rst_l_o(ec_l)
  );

  task automatic chk(string tag, logic [31:0] actual, logic [31:0] expected);
    vec++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [3:0] a, string tag);
    exp_q.push_back(a);
    tag_q.push_back(tag);
  endtask

  task automatic drained(string tag);
    chk({tag, " pending expected actions"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic clear_stat(logic [NC-1:0] m);
    stat_clr = m;
    hold(1);
    stat_clr = '0;
    hold(1);
  endtask

  task automatic measure_ec(int expected, string tag);
    int w = 0;
    int n = 0;
    while (ec_l === 1'b1 && w < 300) begin @(negedge clk); w++; end
    while (ec_l === 1'b0 && n < 1000) begin @(negedge clk); n++; end
    chk(tag, n, expected);
  endtask

  // monitor: every action strobe is scored against the queue
  always @(negedge clk) begin
    if (rst_n && act !== 4'b0) begin
      if (exp_q.size() == 0) begin
        chk("R4/R6/R7/R8 unexpected action", act, 0);
      end else begin
        e_act = exp_q.pop_front();
        e_tag = tag_q.pop_front();
        chk(e_tag, act, e_act);
      end
    end
  end

  initial begin
    pre_sel  = {5'h00, 5'h00, 5'h10, 5'h00};
    com_sel  = {5'h04, 5'h00, 5'h08, 5'h03};
    pre_time = {32'd0, 32'd0, 32'd20, 32'd0};
    com_time = {32'd10, 32'd10, 32'd10, 32'd10};
    act_en   = {4'b0110, 4'b1111, 4'b1100, 4'b0011};

    hold(3);
    chk("R1 act", act, 0);
    chk("R1 stat", stat, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ec_rst_l", ec_l, 1);
    rst_n = 1'b1;
    hold(5);

    // R2: 2-cycle glitch with zero hold time must not fire
    com_time[31:0] = 32'd0;
    keys[1:0] = 2'b00; hold(2); keys[1:0] = 2'b11; hold(30);
    drained("R2");
    push(4'b0011, "R2 stable press");
    keys[1:0] = 2'b00; hold(40); drained("R2");
    keys[1:0] = 2'b11; hold(20);
    com_time[31:0] = 32'd10;
    clear_stat(4'b0001);

    // R3/R9/R10: basic detection of combo 0
    push(4'b0011, "R3 R9 combo0 actions");
    keys[1:0] = 2'b00; hold(40); drained("R3");
    chk("R10 stat after irq combo", stat, 4'b0001);
    chk("R10 irq", irq, 1);
    hold(100); drained("R8 no refire while held");
    keys[1:0] = 2'b11; hold(20);
    clear_stat(4'b0001);
    chk("R10 stat cleared", stat, 0);
    chk("R10 irq cleared", irq, 0);
    push(4'b0011, "R8 refire after release");
    keys[1:0] = 2'b00; hold(40); drained("R8");
    keys[1:0] = 2'b11; hold(20);
    clear_stat(4'b0001);

    // R4: early release
    keys[1:0] = 2'b00; hold(8); keys[1:0] = 2'b11; hold(40);
    drained("R4");

    // R5: precondition unmet / released early
    keys[3] = 1'b0; hold(60); keys[3] = 1'b1; hold(20);
    keys[4] = 1'b0; hold(8); keys[4] = 1'b1;
    keys[3] = 1'b0; hold(40); keys[3] = 1'b1; hold(20);
    drained("R5");

    // R6: combo key already pressed when armed
    keys[3] = 1'b0; hold(20);
    keys[4] = 1'b0; hold(60);
    drained("R6");
    keys[3] = 1'b1; hold(20);
    push(4'b1100, "R6 R5 re-press after arming");
    keys[3] = 1'b0;
    measure_ec(16, "R11 ec pulse cycles");
    hold(30); drained("R6");
    chk("R10 no status without irq action", stat, 0);
    keys[3] = 1'b1; keys[4] = 1'b1; hold(30);

    // R12: timers frozen without tick
    tick = 1'b0;
    keys[2] = 1'b0; hold(60);
    drained("R12");
    push(4'b0110, "R12 fire after tick resumes");
    tick = 1'b1; hold(40); drained("R12");
    chk("R10 stat combo3", stat, 4'b1000);
    keys[2] = 1'b1; hold(40);
    clear_stat(4'b1000);

    // R9: simultaneous fire ORs actions; R7 disabled combo stays silent
    push(4'b0111, "R9 merged actions");
    keys[2:0] = 3'b000; hold(60); drained("R9");
    chk("R9 stat both", stat, 4'b1001);
    chk("R7 disabled combo status", stat[2], 0);
    keys[2:0] = 3'b111; hold(40);

    drained("final");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule